// File: doc/BRIEF.md
# RTC Power-Management Control and Status Register

This block is one 8-bit register for the power-management side of a real-time clock, sitting at a single address on a simple parallel register bus. It keeps three sticky event flags: wake-up alarm, kickstart and RAM clear. A hardware strobe or a software write of 1 sets a flag, and only a software write of 0 clears it. A registered interrupt request is formed from the flags and their enable inputs.

The register also has three control bits. A burst-enable bit goes out to an external RAM address counter. A spare bit can be read and written and does nothing else. A power-release bit controls a pad that can either float or pull the system power enable low. An enabled wake or kickstart flag makes the hardware clear the power-release bit, which turns the power-enable pad on.

A read-only bit reports the backup-cell status. A second read-only bit reports that a time update is near or in progress. It rises a fixed number of prescaler ticks before each update cycle begins and falls when that update ends. The prescaler counts an input tick and gives the start of each update cycle to the timekeeping logic.

Top module: `rtcx_ctrl`

## Requirements
- R1: After reset, reading the register gives 0x08 in bits 5..0, with burst 0, spare 0, power-release 1 and all flags 0. `burst_en`, `pwr_oe`, `irq` and the busy bit (bit 6) are all 0.
- R2: Bit 7 always reads the current value of `cell_ok`. Writes to bit 7 have no effect.
- R3: The event flags are bit 2 (RAM clear), bit 1 (wake) and bit 0 (kickstart). Each one is set by its hardware event or by a selected write with that bit at 1. Each stays set until a selected write with that bit at 0.
- R4: If a hardware event and a selected write of 0 to the same flag happen in the same cycle, the flag is 1 after that edge.
- R5: `ramclr_n` passes through a two-stage synchronizer. A high-to-low transition sets bit 2 only while `ramclr_en` is 1. A falling edge while `ramclr_en` is 0 does not set bit 2, and neither does a rising edge.
- R6: Bit 5 (burst) is read/write and drives `burst_en` directly.
- R7: Bit 3 (power-release) is read/write. At 1, `pwr_oe` is 0 and the pad floats. At 0, `pwr_oe` is 1 and the pad drives low.
- R8: While (wake flag and `wake_ie`) or (kickstart flag and `kick_ie`) is true, the hardware forces bit 3 to 0 at every edge, and a write of 1 to bit 3 does not take effect.
- R9: `irq` is registered. One cycle after any flag is set together with its enable input, `irq` is 1. One cycle after no enabled flag remains, `irq` is 0.
- R10: Bit 6 rises exactly LEAD_TICKS ticks before the `upd_start` pulse and falls UPD_TICKS ticks after it.
- R11: Bit 4 (spare) is read/write and has no effect on any output.
- R12: When `reg_sel` is 0, `reg_rdata` is 0 and a write strobe changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register selected on the bus |
| reg_wr | input | 1 | Write strobe, acts when selected |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not selected |
| cell_ok | input | 1 | Backup cell good, from the battery sensor |
| tick | input | 1 | Prescaler tick enable |
| wake_evt | input | 1 | Wake-up alarm match strobe |
| kick_evt | input | 1 | Kickstart strobe |
| ramclr_n | input | 1 | Asynchronous RAM-clear request, active on falling edge |
| ramclr_en | input | 1 | Enables RAM-clear edge detection |
| wake_ie | input | 1 | Wake flag interrupt enable |
| kick_ie | input | 1 | Kickstart flag interrupt enable |
| rclr_ie | input | 1 | RAM-clear flag interrupt enable |
| burst_en | output | 1 | Auto-increment enable for the RAM address counter |
| pwr_oe | output | 1 | Power-enable pad driver on (pad low when 1, floating when 0) |
| irq | output | 1 | Registered interrupt request |
| upd_start | output | 1 | One-cycle pulse at the start of each update cycle |

## Verification
If a flag is lost or stuck, the next read of bits 2..0 shows it. Where its enable is high, `irq` also shows it one cycle later, and `pwr_oe` turns on one cycle later when wake or kickstart is enabled. If the power-release bit holds the wrong value, `pwr_oe` is wrong in the very next cycle. A set/clear race that resolves the wrong way appears right after the edge that has both. A prescaler that is off by one shows up as a busy window of the wrong length, measured in ticks on each side of the `upd_start` pulse, within one update period.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
   localparam int unsigned CTL_W     = 8;
   localparam int unsigned NUM_FLAGS = 3;

   localparam int unsigned B_CELL  = 7;
   localparam int unsigned B_BUSY  = 6;
   localparam int unsigned B_BURST = 5;
   localparam int unsigned B_SPARE = 4;
   localparam int unsigned B_PWR   = 3;
   localparam int unsigned B_RCLR  = 2;
   localparam int unsigned B_WAKE  = 1;
   localparam int unsigned B_KICK  = 0;

   typedef enum logic [1:0] {
      FLG_KICK = 2'd0,
      FLG_WAKE = 2'd1,
      FLG_RCLR = 2'd2
   } flag_idx_e;

   typedef struct packed {
      logic burst;
      logic spare;
      logic pwr_rel;
   } ctl_bits_t;

   localparam ctl_bits_t CTL_RESET = '{burst: 1'b0, spare: 1'b0, pwr_rel: 1'b1};
endpackage

// File: rtl/rtcx_fall_detect.sv
module rtcx_fall_detect #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic enable,
   output logic fall
);
   logic cur;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign cur = din;
      end else begin : g_sync
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], din};
         end
         assign cur = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= cur;
   end

   assign fall = enable & prev_q & ~cur;
endmodule

// File: rtl/rtcx_event_flag.sv
module rtcx_event_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_val,
   output logic q
);
   logic q_nxt;

   always_comb begin
      q_nxt = q;
      if (sw_wr)  q_nxt = sw_val;
      if (hw_set) q_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_nxt;
   end
endmodule

// File: rtl/rtcx_upd_window.sv
module rtcx_upd_window #(
   parameter int unsigned PERIOD_TICKS = 32768,
   parameter int unsigned LEAD_TICKS   = 4,
   parameter int unsigned UPD_TICKS    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic busy,
   output logic upd_start
);
   localparam int unsigned CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
   localparam logic [CW-1:0] LAST    = CW'(PERIOD_TICKS - 1);
   localparam logic [CW-1:0] LEAD_AT = CW'(PERIOD_TICKS - LEAD_TICKS);
   localparam logic [CW-1:0] UPD_END = CW'(UPD_TICKS);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          wrap;

   assign wrap = tick && (cnt_q == LAST);

   always_comb begin
      cnt_nxt = cnt_q;
      if (tick) cnt_nxt = wrap ? '0 : cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= UPD_END;
         busy      <= 1'b0;
         upd_start <= 1'b0;
      end else begin
         cnt_q     <= cnt_nxt;
         busy      <= (cnt_nxt >= LEAD_AT) || (cnt_nxt < UPD_END);
         upd_start <= wrap;
      end
   end
endmodule

// File: rtl/rtcx_ctrl.sv
module rtcx_ctrl #(
   parameter int unsigned PERIOD_TICKS = 32768,
   parameter int unsigned LEAD_TICKS   = 4,
   parameter int unsigned UPD_TICKS    = 2,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_sel,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       cell_ok,
   input  logic       tick,
   input  logic       wake_evt,
   input  logic       kick_evt,
   input  logic       ramclr_n,
   input  logic       ramclr_en,
   input  logic       wake_ie,
   input  logic       kick_ie,
   input  logic       rclr_ie,
   output logic       burst_en,
   output logic       pwr_oe,
   output logic       irq,
   output logic       upd_start
);
   import rtcx_pkg::*;

   generate
      if (LEAD_TICKS < 1 || UPD_TICKS < 1) begin : g_bad_window
         $error("rtcx_ctrl: lead and update lengths must be at least one tick");
      end
      if (LEAD_TICKS + UPD_TICKS >= PERIOD_TICKS) begin : g_bad_period
         $error("rtcx_ctrl: busy window must be shorter than the update period");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("rtcx_ctrl: synchronizer needs 0 or at least 2 stages");
      end
   endgenerate

   logic                 wr_hit;
   logic                 rclr_fall;
   logic                 busy;
   logic                 auto_rel;
   logic [NUM_FLAGS-1:0] flags;
   logic [NUM_FLAGS-1:0] hw_set;
   logic [NUM_FLAGS-1:0] ie_vec;
   ctl_bits_t            ctl_q;
   ctl_bits_t            ctl_nxt;

   assign wr_hit = reg_sel & reg_wr;

   rtcx_fall_detect #(.STAGES(SYNC_STAGES)) u_rclr (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (ramclr_n),
      .enable (ramclr_en),
      .fall   (rclr_fall)
   );

   rtcx_upd_window #(
      .PERIOD_TICKS (PERIOD_TICKS),
      .LEAD_TICKS   (LEAD_TICKS),
      .UPD_TICKS    (UPD_TICKS)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .busy      (busy),
      .upd_start (upd_start)
   );

   assign hw_set[FLG_KICK] = kick_evt;
   assign hw_set[FLG_WAKE] = wake_evt;
   assign hw_set[FLG_RCLR] = rclr_fall;
   assign ie_vec[FLG_KICK] = kick_ie;
   assign ie_vec[FLG_WAKE] = wake_ie;
   assign ie_vec[FLG_RCLR] = rclr_ie;

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         rtcx_event_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_set[i]),
            .sw_wr  (wr_hit),
            .sw_val (reg_wdata[i]),
            .q      (flags[i])
         );
      end
   endgenerate

   assign auto_rel = (flags[FLG_WAKE] & wake_ie) | (flags[FLG_KICK] & kick_ie);

   always_comb begin
      ctl_nxt = ctl_q;
      if (wr_hit) begin
         ctl_nxt.burst   = reg_wdata[B_BURST];
         ctl_nxt.spare   = reg_wdata[B_SPARE];
         ctl_nxt.pwr_rel = reg_wdata[B_PWR];
      end
      if (auto_rel) ctl_nxt.pwr_rel = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
         irq   <= 1'b0;
      end else begin
         ctl_q <= ctl_nxt;
         irq   <= |(flags & ie_vec);
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel) begin
         reg_rdata[B_CELL]  = cell_ok;
         reg_rdata[B_BUSY]  = busy;
         reg_rdata[B_BURST] = ctl_q.burst;
         reg_rdata[B_SPARE] = ctl_q.spare;
         reg_rdata[B_PWR]   = ctl_q.pwr_rel;
         reg_rdata[B_RCLR]  = flags[FLG_RCLR];
         reg_rdata[B_WAKE]  = flags[FLG_WAKE];
         reg_rdata[B_KICK]  = flags[FLG_KICK];
      end
   end

   assign burst_en = ctl_q.burst;
   assign pwr_oe   = ~ctl_q.pwr_rel;
endmodule

// File: rtl/rtcx_ctrl_chk.sv
module rtcx_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_sel,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic       wake_evt,
   input logic       kick_evt,
   input logic       wake_ie,
   input logic       kick_ie,
   input logic       rclr_ie,
   input logic [2:0] flags,
   input logic       pwr_oe,
   input logic       busy,
   input logic       irq,
   input logic       upd_start
);
   logic wr0_wake;
   logic [2:0] ie_v;
   assign wr0_wake = reg_sel && reg_wr && !reg_wdata[1];
   assign ie_v     = {rclr_ie, wake_ie, kick_ie};

   AST_WAKE_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> flags[1]); // R3
   AST_KICK_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      kick_evt |=> flags[0]); // R3
   AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[1] && !wr0_wake) |=> flags[1]); // R3
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_evt && wr0_wake) |=> flags[1]); // R4
   AST_PWR_AUTO_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags[1] && wake_ie) || (flags[0] && kick_ie)) |=> pwr_oe); // R8
   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags & ie_v)) |=> irq); // R9
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flags & ie_v)) |=> !irq); // R9
   AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      upd_start |-> busy); // R10
endmodule

bind rtcx_ctrl rtcx_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .wake_evt  (wake_evt),
   .kick_evt  (kick_evt),
   .wake_ie   (wake_ie),
   .kick_ie   (kick_ie),
   .rclr_ie   (rclr_ie),
   .flags     (flags),
   .pwr_oe    (pwr_oe),
   .busy      (busy),
   .irq       (irq),
   .upd_start (upd_start)
);

// File: tb/rtcx_ctrl_test.sv
`timescale 1ns/1ps
module rtcx_ctrl_test;
   localparam int unsigned PER  = 64;
   localparam int unsigned LEAD = 4;
   localparam int unsigned UPD  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       cell_ok = 1'b1, tick = 1'b1;
   logic       wake_evt = 1'b0, kick_evt = 1'b0;
   logic       ramclr_n = 1'b1, ramclr_en = 1'b0;
   logic       wake_ie = 1'b0, kick_ie = 1'b0, rclr_ie = 1'b0;
   logic       burst_en, pwr_oe, irq, upd_start;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rtcx_ctrl #(.PERIOD_TICKS(PER), .LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cell_ok(cell_ok),
      .tick(tick), .wake_evt(wake_evt), .kick_evt(kick_evt),
      .ramclr_n(ramclr_n), .ramclr_en(ramclr_en), .wake_ie(wake_ie),
      .kick_ie(kick_ie), .rclr_ie(rclr_ie), .burst_en(burst_en),
      .pwr_oe(pwr_oe), .irq(irq), .upd_start(upd_start));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] v);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   // read with the busy bit (bit 6) masked
   task automatic rd_reg(output logic [7:0] v);
      reg_sel = 1'b1;
      #1 v = reg_rdata & 8'hBF;
      reg_sel = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      @(negedge clk);
      rd_reg(v);
      chk("R1 reset value", v, 8'h88);
      chk("R1 reset outputs", {4'b0, uut.reg_rdata[6], burst_en, pwr_oe, irq}, 8'h00);
   endtask

   task automatic t_cell;
      logic [7:0] v;
      wr_reg(8'h88);
      cell_ok = 1'b0;
      @(negedge clk); rd_reg(v);
      chk("R2 cell low reads 0", v & 8'h80, 8'h00);
      cell_ok = 1'b1;
      #1 rd_reg(v);
      chk("R2 cell high reads 1", v & 8'h80, 8'h80);
   endtask

   task automatic t_flags;
      logic [7:0] v;
      @(negedge clk); wake_evt = 1'b1;
      @(negedge clk); wake_evt = 1'b0;
      rd_reg(v);
      chk("R3 wake event sets bit1", v & 8'h07, 8'h02);
      wr_reg(8'h0D);
      rd_reg(v);
      chk("R3 write 1 sets, write 0 clears", v & 8'h07, 8'h05);
      repeat (3) @(negedge clk);
      rd_reg(v);
      chk("R3 flags hold", v & 8'h07, 8'h05);
      wr_reg(8'h08);
      rd_reg(v);
      chk("R3 write 0 clears all", v & 8'h07, 8'h00);
   endtask

   task automatic t_race;
      logic [7:0] v;
      @(negedge clk);
      kick_evt = 1'b1; reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h08;
      @(negedge clk);
      kick_evt = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
      rd_reg(v);
      chk("R4 set beats clear", v & 8'h07, 8'h01);
      wr_reg(8'h08);
   endtask

   task automatic t_ramclr;
      logic [7:0] v;
      ramclr_en = 1'b0; ramclr_n = 1'b0;
      repeat (5) @(negedge clk);
      rd_reg(v);
      chk("R5 disabled fall ignored", v & 8'h04, 8'h00);
      ramclr_n = 1'b1;
      repeat (5) @(negedge clk);
      ramclr_en = 1'b1;
      repeat (2) @(negedge clk);
      rd_reg(v);
      chk("R5 rising edge ignored", v & 8'h04, 8'h00);
      ramclr_n = 1'b0;
      repeat (5) @(negedge clk);
      rd_reg(v);
      chk("R5 enabled fall sets bit2", v & 8'h04, 8'h04);
      ramclr_en = 1'b0; ramclr_n = 1'b1;
      wr_reg(8'h08);
   endtask

   task automatic t_burst_spare;
      logic [7:0] v;
      wr_reg(8'h28);
      rd_reg(v);
      chk("R6 burst bit reads back", v, 8'hA8);
      chk("R6 burst_en follows", {7'b0, burst_en}, 8'h01);
      wr_reg(8'h18);
      rd_reg(v);
      chk("R11 spare reads back", v, 8'h98);
      chk("R11 spare no effect", {5'b0, burst_en, pwr_oe, irq}, 8'h00);
      wr_reg(8'h08);
   endtask

   task automatic t_power;
      logic [7:0] v;
      wr_reg(8'h00);
      chk("R7 pwr bit 0 drives", {7'b0, pwr_oe}, 8'h01);
      wr_reg(8'h08);
      chk("R7 pwr bit 1 floats", {7'b0, pwr_oe}, 8'h00);
      wake_ie = 1'b1;
      @(negedge clk); wake_evt = 1'b1;
      @(negedge clk); wake_evt = 1'b0;
      @(negedge clk);
      chk("R8 enabled wake turns pad on", {7'b0, pwr_oe}, 8'h01);
      chk("R9 irq from wake", {7'b0, irq}, 8'h01);
      wr_reg(8'h0A);
      rd_reg(v);
      chk("R8 write 1 blocked while enabled flag", v & 8'h0F, 8'h02);
      wake_ie = 1'b0;
      wr_reg(8'h08);
      @(negedge clk);
      chk("R8 pad released after clear", {7'b0, pwr_oe}, 8'h00);
   endtask

   task automatic t_irq;
      wr_reg(8'h0C);
      @(negedge clk);
      chk("R9 disabled flag no irq", {6'b0, irq, pwr_oe}, 8'h00);
      rclr_ie = 1'b1;
      @(negedge clk);
      chk("R9 irq one cycle after enable", {7'b0, irq}, 8'h01);
      chk("R9 rclr flag leaves pad", {7'b0, pwr_oe}, 8'h00);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h08;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0;
      chk("R9 irq still high one edge after clear", {7'b0, irq}, 8'h01);
      @(negedge clk);
      chk("R9 irq drops", {7'b0, irq}, 8'h00);
      rclr_ie = 1'b0;
   endtask

   task automatic t_window;
      int n = 0;
      int m = 0;
      @(negedge clk);
      reg_sel = 1'b1;
      #1;
      while (reg_rdata[6]) @(negedge clk);
      while (!reg_rdata[6]) @(negedge clk);
      do begin @(negedge clk); n++; end while (!upd_start);
      do begin @(negedge clk); m++; end while (reg_rdata[6]);
      reg_sel = 1'b0;
      chk("R10 lead ticks", 8'(n), 8'(LEAD));
      chk("R10 update ticks", 8'(m), 8'(UPD));
   endtask

   task automatic t_unselected;
      logic [7:0] v;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 8'hFF;
      #1 chk("R12 unselected reads 0", reg_rdata, 8'h00);
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
      rd_reg(v);
      chk("R12 unselected write ignored", v, 8'h88);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cell();
      t_flags();
      t_race();
      t_ramclr();
      t_burst_spare();
      t_power();
      t_irq();
      t_window();
      t_unselected();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule